// File: doc/BRIEF.md
# Flash Write-Protection Gate

This block sits behind the command decoder of a serial flash device and decides, for every decoded write-class command, whether the device may act on it. It holds the write-enable latch and the protect code with its lock bit. It turns the protect code into a protected address window anchored at the top of the array, and it compares each program or erase target against that window. The serial shifter and the memory array are not part of it.

The decoder presents one command per cycle on `cmd_valid_i`/`cmd_i` together with the target address. One cycle later the block raises either `accept_o` or `ignore_o` for a write-class command. Chip-select rising edges arrive as single-cycle `cs_rise_i` pulses. The busy flag comes from the internal program/erase timer. The active-low write-protect pin arrives on `wp_ni`.

Top module: `flash_wprot`

## Requirements
- R1: `wel_o` resets to 0. A WREN (cmd 1) presented while `busy_i` is 0 sets `wel_o` from the clock edge that samples it.
- R2: Write-class commands are codes 3..10. Each one produces a one-cycle pulse on exactly one of `accept_o` or `ignore_o`, in the cycle after it is sampled. Any of them is ignored while `wel_o` is 0. Codes 0, 1, 2 and 11..15 produce neither pulse.
- R3: WRDI (cmd 2) clears `wel_o` at the next edge even while `busy_i` is 1, and never touches `busy_i`-driven behaviour.
- R4: An accepted WRSR (cmd 3) loads `wrsr_bp_i` into `bp_o` and `wrsr_lock_i` into `bpl_o` at the sampling edge. `wel_o` stays 1 until the first later `cs_rise_i` pulse, which clears it.
- R5: While `busy_i` is 1, every write-class command is ignored and WREN has no effect. On the cycle after `busy_i` goes from 1 to 0, `wel_o` is 0.
- R6: The protect code decodes as follows. Code 0 protects nothing: `prot_any_o`=0 and `prot_base_o`=0. A code c in 1..7 protects the addresses from `prot_base_o` = 800000h − (10000h << (c−1)) up to 7FFFFFh. Codes 8..15 protect the whole array: `prot_all_o`=1 and `prot_base_o`=0.
- R7: Page program (4), dual-input page program (5), sector erase (6) and block erase (7) are ignored when `addr_i[22:0]` is at or above `prot_base_o` while `prot_any_o` is 1. Address bit 23 is disregarded.
- R8: Chip erase (8) is ignored whenever `bp_o` is nonzero.
- R9: While `bpl_o` is 1 and `wp_ni` is 0, WRSR is ignored and `bp_o`, `bpl_o` and `wel_o` keep their values. With `wp_ni` at 1, WRSR works as in R4.
- R10: Security-ID program (9) and lockout (10) depend only on `wel_o` and `busy_i`, not on the protect code.
- R11: After reset `bp_o` is 15, `bpl_o` is 0, `prot_all_o` is 1, and `accept_o` and `ignore_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Decoded command strobe |
| cmd_i | input | 4 | Command code |
| addr_i | input | 24 | Target address |
| wrsr_bp_i | input | 4 | Protect code carried by WRSR |
| wrsr_lock_i | input | 1 | Lock bit carried by WRSR |
| cs_rise_i | input | 1 | Chip-select rising-edge pulse |
| busy_i | input | 1 | Internal operation in progress |
| wp_ni | input | 1 | Write-protect pin, active low |
| accept_o | output | 1 | Command accepted pulse |
| ignore_o | output | 1 | Command ignored pulse |
| wel_o | output | 1 | Write-enable latch |
| bp_o | output | 4 | Protect code |
| bpl_o | output | 1 | Protect lock bit |
| prot_any_o | output | 1 | Some region is protected |
| prot_all_o | output | 1 | Whole array protected |
| prot_base_o | output | 23 | Lowest protected address |

## Verification
The bench targets the window edge, with erases one below the base and exactly at the base. A comparator off by one lets the first protected sector be erased, or blocks the last free one. It also sets address bit 23 on targets below the base; a design that compares all 24 bits would then refuse legal erases. It checks that WEL survives an accepted WRSR until the following chip-select edge; clearing it early, or never, shows up on `wel_o`. It also runs the lock against both levels of the pin, catches chip erase under a single protected block, and tests WRDI and WREN while busy. A latch that ignored WRDI or obeyed WREN during busy would leave a stale enable behind.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_WREN = 4'd1,
    CMD_WRDI = 4'd2,
    CMD_WRSR = 4'd3,
    CMD_PP   = 4'd4,
    CMD_DPP  = 4'd5,
    CMD_SE   = 4'd6,
    CMD_BE   = 4'd7,
    CMD_CE   = 4'd8,
    CMD_SIDP = 4'd9,
    CMD_SIDL = 4'd10
  } wp_cmd_e;

  function automatic logic is_write_class(logic [3:0] c);
    return (c >= 4'd3) && (c <= 4'd10);
  endfunction
endpackage

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
  parameter int BP_W   = 4,
  parameter int MEM_AW = 23,
  parameter int MIN_AW = 16
) (
  input  logic [BP_W-1:0]   bp_i,
  output logic [MEM_AW-1:0] base_o,
  output logic              any_o,
  output logic              all_o
);
  localparam int NCODE  = 2 ** BP_W;
  localparam int LEVELS = MEM_AW - MIN_AW;

  logic [MEM_AW-1:0] base_lut [NCODE];
  logic [NCODE-1:0]  full_lut;

  for (genvar g = 0; g < NCODE; g++) begin : g_code
    if (g == 0) begin : g_none
      assign base_lut[g] = '0;
      assign full_lut[g] = 1'b0;
    end else if (g <= LEVELS) begin : g_part
      localparam logic [MEM_AW:0] TOP  = {1'b1, {MEM_AW{1'b0}}};
      localparam logic [MEM_AW:0] SPAN = {{MEM_AW{1'b0}}, 1'b1} << (MIN_AW + g - 1);
      localparam logic [MEM_AW:0] BASE = TOP - SPAN;
      assign base_lut[g] = BASE[MEM_AW-1:0];
      assign full_lut[g] = 1'b0;
    end else begin : g_full
      assign base_lut[g] = '0;
      assign full_lut[g] = 1'b1;
    end
  end

  assign base_o = base_lut[bp_i];
  assign all_o  = full_lut[bp_i];
  assign any_o  = (bp_i != '0);
endmodule

// File: rtl/wp_wel_ctrl.sv
module wp_wel_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic wrsr_acc_i,
  input  logic cs_rise_i,
  input  logic busy_i,
  output logic wel_o
);
  logic wel_q, pend_q, busy_q;
  logic busy_fall, clr_all;

  assign busy_fall = busy_q & ~busy_i;
  assign clr_all   = clr_i | busy_fall | (cs_rise_i & pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (clr_all)    wel_q <= 1'b0;
      else if (set_i) wel_q <= 1'b1;
      if (wrsr_acc_i)     pend_q <= 1'b1;
      else if (cs_rise_i) pend_q <= 1'b0;
    end
  end

  assign wel_o = wel_q;

  assert_wren_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !clr_i && !busy_q && !(cs_rise_i && pend_q) |=> wel_o);
  assert_wrdi_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !wel_o);
  assert_cs_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i && pend_q |=> !wel_o);
  assert_busy_fall_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !busy_i |=> !wel_o);
endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg #(
  parameter int              BP_W   = 4,
  parameter logic [BP_W-1:0] RST_BP = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [BP_W-1:0] bp_d_i,
  input  logic            bpl_d_i,
  input  logic            wp_ni,
  output logic [BP_W-1:0] bp_o,
  output logic            bpl_o,
  output logic            locked_o
);
  logic [BP_W-1:0] bp_q;
  logic            bpl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q  <= RST_BP;
      bpl_q <= 1'b0;
    end else if (wr_i) begin
      bp_q  <= bp_d_i;
      bpl_q <= bpl_d_i;
    end
  end

  assign bp_o     = bp_q;
  assign bpl_o    = bpl_q;
  assign locked_o = bpl_q & ~wp_ni;

  assert_no_write_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && locked_o));
  assert_hold_without_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(bp_o) && $stable(bpl_o));
endmodule

// File: rtl/flash_wprot.sv
module flash_wprot #(
  parameter int              ADDR_W = 24,
  parameter int              MEM_AW = 23,
  parameter int              MIN_AW = 16,
  parameter int              BP_W   = 4,
  parameter logic [BP_W-1:0] RST_BP = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BP_W-1:0]   wrsr_bp_i,
  input  logic              wrsr_lock_i,
  input  logic              cs_rise_i,
  input  logic              busy_i,
  input  logic              wp_ni,
  output logic              accept_o,
  output logic              ignore_o,
  output logic              wel_o,
  output logic [BP_W-1:0]   bp_o,
  output logic              bpl_o,
  output logic              prot_any_o,
  output logic              prot_all_o,
  output logic [MEM_AW-1:0] prot_base_o
);
  import wp_pkg::*;

  logic            wel, locked, any, all;
  logic [BP_W-1:0] bp;
  logic            bpl;
  logic [MEM_AW-1:0] base;
  logic            addr_prot, wclass, acc_d, ign_d, wrsr_acc;
  logic            acc_q, ign_q;
  wp_cmd_e         cmd;

  assign cmd = wp_cmd_e'(cmd_i);

  wp_region_decode #(.BP_W(BP_W), .MEM_AW(MEM_AW), .MIN_AW(MIN_AW)) i_decode (
    .bp_i  (bp),
    .base_o(base),
    .any_o (any),
    .all_o (all)
  );

  assign addr_prot = any && (addr_i[MEM_AW-1:0] >= base);
  assign wclass    = cmd_valid_i && is_write_class(cmd_i);

  always_comb begin
    acc_d = 1'b0;
    if (wclass && wel && !busy_i) begin
      unique case (cmd)
        CMD_WRSR:                        acc_d = !locked;
        CMD_PP, CMD_DPP, CMD_SE, CMD_BE: acc_d = !addr_prot;
        CMD_CE:                          acc_d = !any;
        default:                         acc_d = 1'b1;
      endcase
    end
    ign_d = wclass && !acc_d;
  end

  assign wrsr_acc = acc_d && (cmd == CMD_WRSR);

  wp_status_reg #(.BP_W(BP_W), .RST_BP(RST_BP)) i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wrsr_acc),
    .bp_d_i  (wrsr_bp_i),
    .bpl_d_i (wrsr_lock_i),
    .wp_ni   (wp_ni),
    .bp_o    (bp),
    .bpl_o   (bpl),
    .locked_o(locked)
  );

  wp_wel_ctrl i_wel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (cmd_valid_i && cmd == CMD_WREN && !busy_i),
    .clr_i     (cmd_valid_i && cmd == CMD_WRDI),
    .wrsr_acc_i(wrsr_acc),
    .cs_rise_i (cs_rise_i),
    .busy_i    (busy_i),
    .wel_o     (wel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      ign_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ign_q <= ign_d;
    end
  end

  assign accept_o    = acc_q;
  assign ignore_o    = ign_q;
  assign wel_o       = wel;
  assign bp_o        = bp;
  assign bpl_o       = bpl;
  assign prot_any_o  = any;
  assign prot_all_o  = all;
  assign prot_base_o = base;

  assert_accept_needs_wel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(wel_o));
  assert_one_outcome_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && ignore_o));
  assert_busy_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wclass && busy_i |=> ignore_o);
  assert_ce_needs_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd == CMD_CE && bp_o != '0 |=> !accept_o);
endmodule

// File: tb/test_flash_wprot.sv
`timescale 1ns/1ps
module test_flash_wprot;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd = '0;
  logic [23:0] addr = '0;
  logic [3:0]  wbp = '0;
  logic        wbpl = 1'b0;
  logic        cs_rise = 1'b0;
  logic        busy = 1'b0;
  logic        wp_n = 1'b1;
  logic        accept, ignore, wel, bpl, p_any, p_all;
  logic [3:0]  bp;
  logic [22:0] p_base;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit       m_wel = 0, m_bpl = 0, m_pend = 0, m_bprev = 0, m_acc = 0, m_ign = 0;
  bit [3:0] m_bp = 4'hF;
  string    m_tag = "R2";

  always #2.5 clk = ~clk;

  flash_wprot i_flash_wprot (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .addr_i(addr),
    .wrsr_bp_i(wbp), .wrsr_lock_i(wbpl), .cs_rise_i(cs_rise), .busy_i(busy), .wp_ni(wp_n),
    .accept_o(accept), .ignore_o(ignore), .wel_o(wel), .bp_o(bp), .bpl_o(bpl),
    .prot_any_o(p_any), .prot_all_o(p_all), .prot_base_o(p_base)
  );

  function automatic int exp_base(bit [3:0] c);
    if (c == 0 || c > 7) return 0;
    return 32'h800000 - (32'h10000 << (c - 1));
  endfunction

  function automatic bit is_prot(bit [3:0] c, bit [23:0] a);
    if (c == 0) return 0;
    if (c > 7) return 1;
    return int'(a[22:0]) >= exp_base(c);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive, advance the model, check after the edge
  task automatic cyc(bit v, bit [3:0] c, bit [23:0] a, bit [3:0] nbp, bit nbpl,
                     bit cs, bit bz, bit wpn, string tag);
    bit wc, acc, fall, wrsr_ok;
    cmd_valid = v; cmd = c; addr = a; wbp = nbp; wbpl = nbpl;
    cs_rise = cs; busy = bz; wp_n = wpn;
    wc = v && c >= 3 && c <= 10;
    acc = 0;
    m_tag = "R2";
    if (wc) begin
      if (bz) m_tag = "R5";
      else if (!m_wel) m_tag = "R2";
      else begin
        case (c)
          4'd3: begin acc = !(m_bpl && !wpn); m_tag = acc ? "R4" : "R9"; end
          4'd4, 4'd5, 4'd6, 4'd7: begin acc = !is_prot(m_bp, a); m_tag = "R7"; end
          4'd8: begin acc = (m_bp == 0); m_tag = "R8"; end
          default: begin acc = 1; m_tag = "R10"; end
        endcase
      end
    end
    wrsr_ok = acc && c == 3;
    fall = m_bprev && !bz;
    m_acc = acc;
    m_ign = wc && !acc;
    if ((v && c == 2) || fall || (cs && m_pend)) m_wel = 0;
    else if (v && c == 1 && !bz) m_wel = 1;
    if (wrsr_ok) m_pend = 1; else if (cs) m_pend = 0;
    if (wrsr_ok) begin m_bp = nbp; m_bpl = nbpl; end
    m_bprev = bz;
    if (tag != "") m_tag = tag;
    @(posedge clk);
    #1;
    chk(m_tag, "accept", accept, m_acc);
    chk(m_tag, "ignore", ignore, m_ign);
    chk(tag != "" ? tag : "R1", "wel", wel, m_wel);
    chk(tag != "" ? tag : "R4", "bp", bp, m_bp);
    chk(tag != "" ? tag : "R4", "bpl", bpl, m_bpl);
    chk(tag != "" ? tag : "R6", "base", p_base, exp_base(m_bp));
    chk(tag != "" ? tag : "R6", "any", p_any, m_bp != 0);
    chk(tag != "" ? tag : "R6", "all", p_all, m_bp > 7);
    @(negedge clk);
  endtask

  task automatic op(bit [3:0] c, bit [23:0] a, string tag);
    cyc(1, c, a, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic set_bp(bit [3:0] code, bit lk, string tag);
    op(4'd1, 0, tag);
    cyc(1, 4'd3, 0, code, lk, 0, 0, 1, tag);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, tag);
  endtask

  task automatic finish_busy(string tag);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit bz;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk("R11", "accept", accept, 0);
    chk("R11", "ignore", ignore, 0);
    chk("R11", "wel", wel, 0);
    chk("R11", "bp", bp, 15);
    chk("R11", "bpl", bpl, 0);
    chk("R11", "all", p_all, 1);
    rst_n = 1'b1;
    @(negedge clk);

    op(4'd4, 24'h000100, "R2");            // no WEL
    op(4'd1, 0, "R1");                     // WREN
    cyc(1, 4'd3, 0, 4'd0, 0, 0, 0, 1, "R4");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, "R4");     // WEL still held
    cyc(0, 0, 0, 0, 0, 1, 0, 1, "R4");     // cs edge clears
    op(4'd1, 0, "R1");
    op(4'd8, 0, "R8");                     // chip erase with bp 0
    cyc(1, 4'd1, 0, 0, 0, 0, 1, 1, "R5");  // WREN while busy
    cyc(1, 4'd4, 24'h10, 0, 0, 0, 1, 1, "R5");
    cyc(1, 4'd2, 0, 0, 0, 0, 1, 1, "R3");  // WRDI while busy
    cyc(0, 0, 0, 0, 0, 0, 0, 1, "R5");
    op(4'd1, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, "R5");     // busy fall clears WEL

    for (int k = 0; k < 16; k++) set_bp(4'(k), 0, "R6");

    set_bp(4'd3, 0, "R6");
    op(4'd1, 0, "R1");
    op(4'd6, 24'h7BFFFF, "R7");
    finish_busy("R7");
    op(4'd1, 0, "R1");
    op(4'd6, 24'h7C0000, "R7");
    op(4'd7, 24'hFBFFFF, "R7");            // bit 23 disregarded
    op(4'd5, 24'hFC0000, "R7");
    op(4'd8, 0, "R8");                     // partial region blocks chip erase
    op(4'd9, 0, "R10");
    finish_busy("R10");
    set_bp(4'd1, 0, "R8");
    op(4'd1, 0, "R8");
    op(4'd8, 0, "R8");

    set_bp(4'd2, 1, "R9");
    op(4'd1, 0, "R9");
    cyc(1, 4'd3, 0, 4'd0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R9");
    cyc(1, 4'd3, 0, 4'd0, 0, 0, 0, 1, "R9");
    cyc(0, 0, 0, 0, 0, 1, 0, 1, "R9");
    set_bp(4'd15, 0, "R10");
    op(4'd1, 0, "R10");
    op(4'd10, 0, "R10");
    finish_busy("R10");

    bz = 0;
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit v;
      bit [3:0] c, nb;
      bit [23:0] a;
      r = int'($urandom % 20);
      v = 1;
      if (r <= 4) c = 1;
      else if (r == 5) c = 2;
      else if (r <= 8) c = 3;
      else if (r <= 16) c = 4'(r - 5);
      else begin v = 0; c = 4'($urandom); end
      nb = 4'($urandom % 10);
      if (nb >= 8) nb = 4'($urandom);
      if ($urandom % 2 == 0) begin
        a = 24'(exp_base(m_bp));
        a = a + 24'(int'($urandom % 3) - 1);
        a[23] = 1'($urandom);
      end else a = 24'($urandom);
      if ($urandom % 12 == 0) bz = ~bz;
      cyc(v, c, a, nb, ($urandom % 4) == 0, ($urandom % 3) == 0, bz,
          ($urandom % 8) != 0, "");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule